// File: doc/BRIEF.md
# Peripheral Interrupt Event Collector

This block sits between one peripheral and a top-level interrupt controller. Each event line from the peripheral is a one-cycle pulse. An event is captured into a sticky pending bit that holds until software acknowledges it. A mask register decides which pending bits may drive the single level-sensitive request line.

Events are never counted or queued. When an enabled event repeats while its pending bit is still set, the repeat is lost. The loss is recorded in a separate overflow register. Software acknowledges that register in the same way as the pending bits.

Software reaches the three registers through a plain strobe interface. There is one write-data bus, one write strobe per register, and a two-bit read selector that drives a combinational read bus.

Top module: `irq_gather`

## Requirements
- R1: A cycle with `wr_mask` high loads `wr_data` into the mask register, so a 1 enables a bit and a 0 disables it. The mask is readable when `rd_sel` = 1.
- R2: An event pulse on `evt_i[i]` sets pending bit i at the next clock edge, whatever the value of mask bit i. Pending bits are readable when `rd_sel` = 0.
- R3: A cycle with `wr_pend` high clears every pending bit where `wr_data` is 1. Pending bits where `wr_data` is 0 keep their value.
- R4: If an event on bit i arrives in the same cycle as a write-1 clear of pending bit i, the pending bit stays set.
- R5: `irq_o` is high exactly when some bit is both pending and enabled. It stays high until every such bit has been cleared or masked.
- R6: If the mask bit of an already pending bit is written to 1, `irq_o` is high in the cycle that follows the write.
- R7: An event on bit i sets overflow bit i when three conditions hold in that cycle: mask bit i is 1, pending bit i is already 1, and pending bit i is not being cleared. An event on a masked bit never sets overflow bit i. Overflow bits are readable when `rd_sel` = 2.
- R8: A cycle with `wr_ovf` high clears every overflow bit where `wr_data` is 1. A new overflow on the same bit in that cycle wins, so the bit stays set.
- R9: After reset all registers are zero and `irq_o` is low. Reads have no side effects. `rd_sel` = 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | W | Single-cycle event pulses, one per bit |
| wr_data | input | W | Write data for all registers |
| wr_pend | input | 1 | Write-1-to-clear strobe for the pending register |
| wr_mask | input | 1 | Load strobe for the mask register |
| wr_ovf | input | 1 | Write-1-to-clear strobe for the overflow register |
| rd_sel | input | 2 | Read select: 0 pending, 1 mask, 2 overflow, 3 zero |
| rd_data | output | W | Selected register contents |
| irq_o | output | 1 | Level-sensitive combined interrupt request |

## Verification
The bench first sends events into a fully masked block. This shows that latching the pending bits is independent of the mask and of the request line. Directed cycles then place an event and a write-1 clear on the same bit, and on different bits. These cycles separate set-wins priority from plain clearing, and they test the overflow rule both with and without a clear in the same cycle. Enabling a mask bit after its event has arrived shows that the request is computed from the stored state and not from the event edge. A long run of random events, strobes and data, compared every cycle against a behavioural model, covers the remaining mixes of these cases.

// File: rtl/irq_gather.sv
module irq_gather #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] wr_data,
  input  logic         wr_pend,
  input  logic         wr_mask,
  input  logic         wr_ovf,
  input  logic [1:0]   rd_sel,
  output logic [W-1:0] rd_data,
  output logic         irq_o
);

  logic [W-1:0] pend_q, mask_q, ovf_q;
  logic [W-1:0] pend_clr, ovf_clr, lost;

  assign pend_clr = wr_pend ? wr_data : '0;
  assign ovf_clr  = wr_ovf  ? wr_data : '0;
  assign lost     = evt_i & mask_q & pend_q & ~pend_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
      ovf_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~pend_clr) | evt_i;
      ovf_q  <= (ovf_q & ~ovf_clr) | lost;
      if (wr_mask) mask_q <= wr_data;
    end
  end

  assign irq_o = |(pend_q & mask_q);

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = pend_q;
      2'd1:    rd_data = mask_q;
      2'd2:    rd_data = ovf_q;
      default: rd_data = '0;
    endcase
  end

endmodule

module irq_gather_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] evt_i,
  input logic [W-1:0] wr_data,
  input logic         wr_pend,
  input logic         wr_mask,
  input logic         wr_ovf,
  input logic         irq_o,
  input logic [W-1:0] pend_q,
  input logic [W-1:0] mask_q,
  input logic [W-1:0] ovf_q
);

  // R2
  evt_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));

  // R3
  pend_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend |=> ((pend_q & $past(wr_data & ~evt_i)) == '0));

  // R4
  pend_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && |(evt_i & wr_data)) |=> ((pend_q & $past(evt_i & wr_data)) == $past(evt_i & wr_data)));

  // R6
  late_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && !wr_pend && |(wr_data & pend_q)) |=> irq_o);

  // R7
  ovf_on_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_pend && |(evt_i & pend_q & mask_q)) |=> (|ovf_q));

  // R8
  ovf_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ovf && !(|evt_i)) |=> ((ovf_q & $past(wr_data)) == '0));

  // R1
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(wr_data)));

endmodule

bind irq_gather irq_gather_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_data(wr_data),
  .wr_pend(wr_pend), .wr_mask(wr_mask), .wr_ovf(wr_ovf), .irq_o(irq_o),
  .pend_q(pend_q), .mask_q(mask_q), .ovf_q(ovf_q)
);

// File: tb/irq_gather_tb.sv
module irq_gather_tb_top;
  localparam int W = 16;
  localparam time PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] evt_i = '0, wr_data = '0, rd_data;
  logic wr_pend = 1'b0, wr_mask = 1'b0, wr_ovf = 1'b0, irq_o;
  logic [1:0] rd_sel = 2'd0;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [W-1:0] m_pend = '0, m_mask = '0, m_ovf = '0;

  irq_gather #(.W(W)) dut_i (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    rd_sel = 2'd0; #1; chk("R2 R3 R4 pending", rd_data, m_pend);
    rd_sel = 2'd1; #1; chk("R1 mask", rd_data, m_mask);
    rd_sel = 2'd2; #1; chk("R7 R8 overflow", rd_data, m_ovf);
    rd_sel = 2'd3; #1; chk("R9 unused select", rd_data, '0);
    chk("R5 irq level", {{(W-1){1'b0}}, irq_o}, {{(W-1){1'b0}}, |(m_pend & m_mask)});
  endtask

  task automatic step(logic [W-1:0] ev, logic wp, logic wm, logic wo, logic [W-1:0] wd);
    logic [W-1:0] pc, oc, ls;
    evt_i = ev; wr_pend = wp; wr_mask = wm; wr_ovf = wo; wr_data = wd;
    @(posedge clk);
    pc = wp ? wd : '0;
    oc = wo ? wd : '0;
    ls = '0;
    for (int i = 0; i < W; i++)
      if (ev[i] && m_mask[i] && m_pend[i] && !pc[i]) ls[i] = 1'b1;
    m_ovf  = (m_ovf & ~oc) | ls;
    m_pend = (m_pend & ~pc) | ev;
    if (wm) m_mask = wd;
    @(negedge clk);
    evt_i = '0; wr_pend = 0; wr_mask = 0; wr_ovf = 0;
    compare_all();
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    compare_all();
    // R2 events latch while fully masked, no irq
    step(16'h00A5, 0, 0, 0, '0);
    step(16'h00A5, 0, 0, 0, '0);  // R7 masked repeats: no overflow
    // R6 enable a pending bit -> irq next cycle
    step('0, 0, 1, 0, 16'h0004);
    chk("R6 late enable", {{(W-1){1'b0}}, irq_o}, {{(W-1){1'b0}}, 1'b1});
    // R3 write 0 has no effect, write 1 clears
    step('0, 1, 0, 0, 16'h0000);
    step('0, 1, 0, 0, 16'h0001);
    // R4 set wins over same-cycle clear
    step(16'h0004, 1, 0, 0, 16'h0004);
    // R7 enabled repeat while pending sets overflow
    step(16'h0004, 0, 0, 0, '0);
    // R5 irq stays while any enabled pending remains
    step('0, 0, 1, 0, 16'h00A4);
    step('0, 1, 0, 0, 16'h0004);
    step('0, 1, 0, 0, 16'h00A0);
    // R8 overflow clear and set-wins
    step(16'h0020, 0, 0, 0, '0);
    step(16'h0020, 0, 0, 1, 16'h0020);
    step('0, 0, 0, 1, 16'h0000);
    step('0, 0, 0, 1, 16'hFFFF);
    // random mix
    for (int n = 0; n < 400; n++)
      step(W'($urandom) & W'($urandom), ($urandom % 3) == 0, ($urandom % 5) == 0,
           ($urandom % 4) == 0, W'($urandom));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule